// File: doc/BRIEF.md
# Serial Display Command and Pixel Transmitter

This block drives a small display controller over four serial wires: a serial clock, a data line, an active-low chip select and a data/command select line. It also drives an active-low reset pin. The host sees a single request port. A request carries an operation code, a 16-bit payload and a repeat count. The block turns the request into one or more bytes. It shifts each byte out most significant bit first in SPI mode 0. The select line is set to the command or data level before the first bit goes out and is held there for the whole operation.

After its own reset the block runs the display's power-up sequence before it accepts any work. It first waits a long settle time. It then holds the reset pin low for a short pulse, with chip select low and the select line high. It then waits the settle time again. Every interval is counted in system clocks. A fill request sends one 16-bit pixel value a programmed number of times inside a single chip-select window, so the host does not have to feed each pixel. The host watches `busy` and a one-cycle `done` strobe.

Top module: `lcd_link_tx`

## Requirements
- R1: While `rst_n` is low, `lcd_rst_n`, `lcd_dc` and `lcd_cs_n` are 1, `lcd_sclk` is 0, `busy` is 1 and `done` is 0.
- R2: After `rst_n` rises, `lcd_rst_n` stays 1 for T_WAIT clocks and is then 0 for exactly T_PULSE clocks. During the pulse `lcd_cs_n` is 0 and `lcd_dc` is 1. `busy` then stays 1 for T_WAIT more clocks before it falls.
- R3: `lcd_sclk` idles low. Each byte gives 8 rising edges, and `lcd_mosi` carries the bits most significant first, stable for the whole time the clock is high.
- R4: Operation codes on `req_op` are 0 = 8-bit command, 1 = 8-bit data, 2 = 16-bit command, 3 = 16-bit data, 4 = one pixel and 5 = pixel fill. `lcd_dc` is 0 for codes 0 and 2 and 1 for the other codes. It does not change while chip select is low, and it idles at 1.
- R5: Codes 2, 3 and 4 send `req_data[15:8]` and then `req_data[7:0]` in one chip-select window. Codes 0 and 1 send only `req_data[7:0]`.
- R6: Code 5 sends the high byte and then the low byte of `req_data`, repeated `req_count` times, all in one chip-select window.
- R7: Code 5 with `req_count` = 0 raises `done` on the clock after acceptance. It does not lower chip select and does not toggle `lcd_sclk`.
- R8: A request is taken when `req_valid` is 1 and both `busy` and `done` are 0. A request presented at any other time has no effect. `busy` is 1 from the clock after acceptance until the operation ends, and `done` is a single-clock pulse at the end.
- R9: Every high phase of `lcd_sclk` lasts exactly HALF_DIV clocks, and every low phase inside a transfer lasts at least HALF_DIV clocks.
- R10: `lcd_sclk` is high only while `lcd_cs_n` is 0. Chip select rises with the clock low and at least HALF_DIV clocks after the last rising clock edge.
- R11: Operation codes 6 and 7 are ignored. `busy` stays 0, no `done` is produced and chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_data | input | 16 | Byte (low half) or 16-bit word / pixel payload |
| req_count | input | CNT_W | Repeat count for fill |
| busy | output | 1 | Start-up sequence or transfer in progress |
| done | output | 1 | One-clock completion strobe |
| lcd_sclk | output | 1 | Serial clock to display |
| lcd_mosi | output | 1 | Serial data to display |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_dc | output | 1 | Data/command select (0 = command) |
| lcd_rst_n | output | 1 | Display reset, active low |

## Verification
The bench builds the block with HALF_DIV = 2, CNT_W = 8, T_WAIT = 40 and T_PULSE = 10. The short timers let the whole start-up sequence be timed clock by clock inside a short run. A divider of 2 makes each clock phase span more than one system clock, so the bench can measure the high-phase length, the spacing from the last rising edge to chip-select release and the hold of the data line across the high phase. The fill counts are kept to 0, 2 and 3 so that the empty fill and multi-repeat windows are covered while the expected byte stream stays small.

// File: rtl/lcd_link_pkg.sv
package lcd_link_pkg;

   typedef enum logic [2:0] {
      OP_CMD8  = 3'd0,
      OP_DAT8  = 3'd1,
      OP_CMD16 = 3'd2,
      OP_DAT16 = 3'd3,
      OP_PIXEL = 3'd4,
      OP_FILL  = 3'd5
   } lcd_op_e;

   typedef enum logic [1:0] {
      PR_HOLD,
      PR_PULSE,
      PR_SETTLE,
      PR_READY
   } por_state_e;

   function automatic logic op_known(input logic [2:0] op);
      return op <= 3'd5;
   endfunction

   function automatic logic op_is_cmd(input logic [2:0] op);
      return (op == OP_CMD8) || (op == OP_CMD16);
   endfunction

   function automatic logic op_is_wide(input logic [2:0] op);
      return (op == OP_CMD16) || (op == OP_DAT16) ||
             (op == OP_PIXEL) || (op == OP_FILL);
   endfunction

endpackage

// File: rtl/lcd_link_por.sv
module lcd_link_por
   import lcd_link_pkg::*;
#(
   parameter int T_WAIT  = 1500000,
   parameter int T_PULSE = 5000
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_out_n,
   output logic cs_force_low,
   output logic ready
);
   localparam int MAXT = (T_WAIT > T_PULSE) ? T_WAIT : T_PULSE;
   localparam int CW   = $clog2(MAXT + 1);
   localparam logic [CW-1:0] WAIT_LAST  = CW'(T_WAIT - 1);
   localparam logic [CW-1:0] PULSE_LAST = CW'(T_PULSE - 1);

   if (T_WAIT < 1) begin : g_bad_wait
      $error("T_WAIT must be at least 1");
   end
   if (T_PULSE < 1) begin : g_bad_pulse
      $error("T_PULSE must be at least 1");
   end

   por_state_e      st;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PR_HOLD;
         cnt <= '0;
      end else begin
         unique case (st)
            PR_HOLD: begin
               if (cnt == WAIT_LAST) begin
                  cnt <= '0;
                  st  <= PR_PULSE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PR_PULSE: begin
               if (cnt == PULSE_LAST) begin
                  cnt <= '0;
                  st  <= PR_SETTLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PR_SETTLE: begin
               if (cnt == WAIT_LAST) begin
                  cnt <= '0;
                  st  <= PR_READY;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               cnt <= '0;
               st  <= PR_READY;
            end
         endcase
      end
   end

   assign rst_out_n    = (st != PR_PULSE);
   assign cs_force_low = (st == PR_PULSE);
   assign ready        = (st == PR_READY);

   // once the sequence completes it never restarts without a block reset
   p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

endmodule

// File: rtl/lcd_link_shift.sv
module lcd_link_shift #(
   parameter int HALF_DIV = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] din,
   output logic       sclk,
   output logic       mosi,
   output logic       active,
   output logic       byte_done
);
   localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int RUN_W = $clog2(HALF_DIV + 2);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic       tick;
   logic [7:0] shreg;
   logic [2:0] bitcnt;
   logic       load;

   assign load = start && !active;

   if (HALF_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
      logic [DIV_W-1:0] divcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            divcnt <= '0;
         end else if (load || !active) begin
            divcnt <= '0;
         end else if (divcnt == DIV_LAST) begin
            divcnt <= '0;
         end else begin
            divcnt <= divcnt + 1'b1;
         end
      end
      assign tick = (divcnt == DIV_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk      <= 1'b0;
         active    <= 1'b0;
         shreg     <= '0;
         bitcnt    <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (load) begin
            shreg  <= din;
            bitcnt <= '0;
            active <= 1'b1;
            sclk   <= 1'b0;
         end else if (active && tick) begin
            if (!sclk) begin
               sclk <= 1'b1;
            end else begin
               sclk <= 1'b0;
               if (bitcnt == 3'd7) begin
                  active    <= 1'b0;
                  byte_done <= 1'b1;
               end else begin
                  bitcnt <= bitcnt + 1'b1;
                  shreg  <= {shreg[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign mosi = active & shreg[7];

   // length of the current high phase, for the phase-width check
   logic [RUN_W-1:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_run <= '0;
      else if (sclk)   hi_run <= hi_run + 1'b1;
      else             hi_run <= '0;
   end

   p_high_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (int'(hi_run) == HALF_DIV));

   p_high_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(hi_run) <= HALF_DIV);

   p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/lcd_link_seq.sv
module lcd_link_seq
   import lcd_link_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ready,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [15:0]      req_data,
   input  logic [CNT_W-1:0] req_count,
   input  logic             byte_done,
   output logic             start,
   output logic [7:0]       byte_out,
   output logic             cs_n,
   output logic             dc,
   output logic             run,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [15:0]      word;
   logic             wide;
   logic             on_hi;
   logic [CNT_W-1:0] reps;
   logic             take;
   logic             empty_fill;

   assign take       = ready && !run && !done && req_valid && op_known(req_op);
   assign empty_fill = (req_op == OP_FILL) && (req_count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word     <= '0;
         wide     <= 1'b0;
         on_hi    <= 1'b0;
         reps     <= '0;
         start    <= 1'b0;
         byte_out <= '0;
         cs_n     <= 1'b1;
         dc       <= 1'b1;
         run      <= 1'b0;
         done     <= 1'b0;
      end else begin
         start <= 1'b0;
         done  <= 1'b0;
         if (take) begin
            if (empty_fill) begin
               done <= 1'b1;
            end else begin
               run      <= 1'b1;
               cs_n     <= 1'b0;
               dc       <= !op_is_cmd(req_op);
               word     <= req_data;
               wide     <= op_is_wide(req_op);
               on_hi    <= op_is_wide(req_op);
               reps     <= (req_op == OP_FILL) ? req_count : ONE;
               byte_out <= op_is_wide(req_op) ? req_data[15:8] : req_data[7:0];
               start    <= 1'b1;
            end
         end else if (run && byte_done) begin
            if (on_hi) begin
               byte_out <= word[7:0];
               on_hi    <= 1'b0;
               start    <= 1'b1;
            end else if (reps != ONE) begin
               reps     <= reps - 1'b1;
               byte_out <= wide ? word[15:8] : word[7:0];
               on_hi    <= wide;
               start    <= 1'b1;
            end else begin
               run  <= 1'b0;
               cs_n <= 1'b1;
               dc   <= 1'b1;
               done <= 1'b1;
            end
         end
      end
   end

   p_dc_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(dc));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_empty_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !run && !done && req_valid && req_op == OP_FILL && req_count == '0)
         |=> (done && cs_n && !run));

   p_unknown_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && req_valid && !op_known(req_op)) |=> (!run && !done));

endmodule

// File: rtl/lcd_link_tx.sv
module lcd_link_tx
   import lcd_link_pkg::*;
#(
   parameter int HALF_DIV = 5,
   parameter int CNT_W    = 17,
   parameter int T_WAIT   = 1500000,
   parameter int T_PULSE  = 5000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [15:0]      req_data,
   input  logic [CNT_W-1:0] req_count,
   output logic             busy,
   output logic             done,
   output logic             lcd_sclk,
   output logic             lcd_mosi,
   output logic             lcd_cs_n,
   output logic             lcd_dc,
   output logic             lcd_rst_n
);
   logic       por_ready;
   logic       por_cs_low;
   logic       seq_start;
   logic [7:0] seq_byte;
   logic       seq_cs_n;
   logic       seq_run;
   logic       sh_active;
   logic       sh_done;

   lcd_link_por #(.T_WAIT(T_WAIT), .T_PULSE(T_PULSE)) u_por (
      .clk          (clk),
      .rst_n        (rst_n),
      .rst_out_n    (lcd_rst_n),
      .cs_force_low (por_cs_low),
      .ready        (por_ready)
   );

   lcd_link_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready     (por_ready),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_data  (req_data),
      .req_count (req_count),
      .byte_done (sh_done),
      .start     (seq_start),
      .byte_out  (seq_byte),
      .cs_n      (seq_cs_n),
      .dc        (lcd_dc),
      .run       (seq_run),
      .done      (done)
   );

   lcd_link_shift #(.HALF_DIV(HALF_DIV)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (seq_start),
      .din       (seq_byte),
      .sclk      (lcd_sclk),
      .mosi      (lcd_mosi),
      .active    (sh_active),
      .byte_done (sh_done)
   );

   assign lcd_cs_n = seq_cs_n & ~por_cs_low;
   assign busy     = ~por_ready | seq_run;

   p_pulse_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_rst_n |-> (!lcd_cs_n && lcd_dc && busy));

   p_sclk_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_sclk |-> !lcd_cs_n);

   p_cs_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_cs_n) |-> (!lcd_sclk && $past(!lcd_sclk)));

   p_shift_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sh_active |-> seq_run);

endmodule

// File: tb/lcd_link_tx_test.sv
`timescale 1ns/1ps
module lcd_link_tx_test;
   localparam int HD = 2;
   localparam int CW = 8;
   localparam int TW = 40;
   localparam int TP = 10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [2:0]    req_op;
   logic [15:0]   req_data;
   logic [CW-1:0] req_count;
   logic busy, done, lcd_sclk, lcd_mosi, lcd_cs_n, lcd_dc, lcd_rst_n;

   always #5 clk = ~clk;

   lcd_link_tx #(.HALF_DIV(HD), .CNT_W(CW), .T_WAIT(TW), .T_PULSE(TP)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_data(req_data), .req_count(req_count), .busy(busy), .done(done),
      .lcd_sclk(lcd_sclk), .lcd_mosi(lcd_mosi), .lcd_cs_n(lcd_cs_n),
      .lcd_dc(lcd_dc), .lcd_rst_n(lcd_rst_n)
   );

   int checks = 0;
   int errors = 0;
   logic [8:0] expq[$];
   logic [8:0] exp_item;
   logic [7:0] sh = '0;
   int bitn = 0;
   int win_bytes = 0;
   int cs_falls = 0;
   int sclk_rises = 0;
   bit win_rise = 0;
   time t_rise = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: collect bits on rising serial clock and compare with scoreboard
   always @(negedge lcd_cs_n) begin
      win_bytes = 0;
      bitn      = 0;
      win_rise  = 0;
      cs_falls++;
   end

   always @(posedge lcd_sclk) begin
      t_rise = $time;
      sclk_rises++;
      win_rise = 1;
      #1;
      sh = {sh[6:0], lcd_mosi};
      bitn++;
      if (bitn == 8) begin
         bitn = 0;
         win_bytes++;
         if (expq.size() == 0) begin
            chk(0, "R3 byte with nothing expected", {lcd_dc, sh}, 0);
         end else begin
            exp_item = expq.pop_front();
            chk({lcd_dc, sh} == exp_item, "R3/R4 byte and D/C level", {lcd_dc, sh}, exp_item);
         end
      end
   end

   always @(negedge lcd_sclk) begin
      if (t_rise != 0)
         chk(($time - t_rise) == HD * 10, "R9 high phase length ns",
             int'($time - t_rise), HD * 10);
   end

   always @(posedge lcd_cs_n) begin
      if (win_rise) begin
         chk(lcd_sclk == 1'b0 && ($time - t_rise) >= HD * 10,
             "R10 chip select release spacing ns", int'($time - t_rise), HD * 10);
         win_rise = 0;
      end
   end

   // driver: queue expected bytes, present the request, wait for the strobe
   task automatic run_op(input logic [2:0] op, input logic [15:0] data,
                         input int count, input string tag);
      bit wide;
      bit dcv;
      int reps;
      int nbytes;
      int falls0;
      int n;
      wide   = (op >= 3'd2);
      dcv    = !(op == 3'd0 || op == 3'd2);
      reps   = (op == 3'd5) ? count : 1;
      nbytes = reps * (wide ? 2 : 1);
      for (int r = 0; r < reps; r++) begin
         if (wide) expq.push_back({dcv, data[15:8]});
         expq.push_back({dcv, data[7:0]});
      end
      while (busy || done) @(negedge clk);
      falls0    = cs_falls;
      req_valid = 1'b1;
      req_op    = op;
      req_data  = data;
      req_count = CW'(count);
      @(negedge clk);
      req_valid = 1'b0;
      if (nbytes > 0) chk(busy == 1'b1, {tag, " R8 busy after accept"}, busy, 1);
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, {tag, " R8 done strobe seen"}, done, 1);
      if (nbytes == 0) begin
         chk(n == 0, {tag, " R7 done on first clock"}, n, 0);
         chk(cs_falls == falls0, {tag, " R7 no chip select"}, cs_falls - falls0, 0);
      end else begin
         chk(cs_falls == falls0 + 1, {tag, " R5/R6 single window"}, cs_falls - falls0, 1);
         chk(win_bytes == nbytes, {tag, " R5/R6 bytes in window"}, win_bytes, nbytes);
      end
      chk(expq.size() == 0, {tag, " R3 all bytes delivered"}, expq.size(), 0);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, {tag, " R8 one-clock strobe"}, {done, busy}, 0);
      chk(lcd_dc == 1'b1 && lcd_cs_n == 1'b1, {tag, " R4 idle levels"}, {lcd_dc, lcd_cs_n}, 3);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      finish_run();
   end

   initial begin
      int n;
      int rises0;
      int falls0;
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_op    = '0;
      req_data  = '0;
      req_count = '0;
      repeat (3) @(negedge clk);
      // R1 reset levels
      chk({lcd_rst_n, lcd_dc, lcd_cs_n, lcd_sclk, busy, done} == 6'b111010,
          "R1 reset levels", {lcd_rst_n, lcd_dc, lcd_cs_n, lcd_sclk, busy, done}, 6'b111010);
      rst_n = 1'b1;

      // R2 start-up sequence timing
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (lcd_rst_n && n < 1000);
      chk(n == TW, "R2 first wait length", n, TW);
      n = 0;
      while (!lcd_rst_n && n < 1000) begin
         chk(lcd_cs_n == 1'b0 && lcd_dc == 1'b1, "R2 pins during pulse", {lcd_cs_n, lcd_dc}, 1);
         @(negedge clk);
         n++;
      end
      chk(n == TP, "R2 pulse length", n, TP);
      n = 0;
      while (busy && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(n == TW, "R2 second wait length", n, TW);
      chk(lcd_cs_n == 1'b1 && lcd_sclk == 1'b0, "R10 idle after start-up", {lcd_cs_n, lcd_sclk}, 2);

      run_op(3'd0, 16'h002C, 0, "cmd8");
      run_op(3'd1, 16'h0081, 0, "dat8");
      run_op(3'd2, 16'hB1C4, 0, "cmd16");
      run_op(3'd3, 16'h0F70, 0, "dat16");
      run_op(3'd4, 16'hF800, 0, "pixel");
      run_op(3'd5, 16'hA55A, 3, "fill3");
      run_op(3'd5, 16'h7777, 2, "fill2");
      run_op(3'd5, 16'h1234, 0, "fill0");

      // R11 unassigned codes leave the block idle
      for (int c = 6; c < 8; c++) begin
         falls0    = cs_falls;
         req_valid = 1'b1;
         req_op    = 3'(c);
         req_data  = 16'hFFFF;
         @(negedge clk);
         req_valid = 1'b0;
         n = 0;
         for (int k = 0; k < 10; k++) begin
            if (busy || done || !lcd_cs_n) n++;
            @(negedge clk);
         end
         chk(n == 0 && cs_falls == falls0, "R11 unknown code ignored", n, 0);
      end

      // R8 a request while busy has no effect
      expq.push_back({1'b1, 8'h12});
      expq.push_back({1'b1, 8'h34});
      falls0    = cs_falls;
      req_valid = 1'b1;
      req_op    = 3'd4;
      req_data  = 16'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R8 busy mid transfer", busy, 1);
      req_valid = 1'b1;
      req_op    = 3'd0;
      req_data  = 16'h0055;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(win_bytes == 2, "R8 only first request sent", win_bytes, 2);
      rises0 = sclk_rises;
      repeat (30) @(negedge clk);
      chk(sclk_rises == rises0 && cs_falls == falls0 + 1 && expq.size() == 0,
          "R8 busy request dropped", sclk_rises - rises0, 0);

      // a normal request still works afterwards
      run_op(3'd1, 16'h00C3, 0, "after");

      finish_run();
   end

endmodule